// File: doc/BRIEF.md
# Modulo Timer with Guarded Overflow Flag

A 16-bit timer counter for a peripheral bus. Software programs a modulo value and a single control register. Three fields of that register set how the counter runs: the clock source, a power-of-two prescale and the counting direction. The counter either counts upward and wraps to zero after the modulo value, or sweeps up to the modulo value and back down to zero. Each completed period sets an overflow flag. When the matching enable bit is set, the flag drives an interrupt line.

The flag can only be cleared by a two-step handshake. Software first reads the control register while the flag is set. It then writes the register with the flag bit at zero. An overflow that arrives between those two steps cancels the handshake, so a period that ends during the clear is never lost. Writing a one to the flag bit does nothing. The counter can be driven by the bus clock, by a single-cycle enable from a fixed-rate source, or by the rising edges of an asynchronous external clock. The external clock is synchronized inside the block.

Top module: `ovf_timer`

## Requirements
- R1: After reset the control register, the count, the modulo register and `irq` are all 0. Address 0 is the control register and holds zero-extended bits [7:0]: bit 7 is the overflow flag, bit 6 the interrupt enable, bit 5 the center (up/down) select, bits 4:3 the clock select and bits 2:0 the prescale. Address 1 reads the count and ignores writes. Address 2 is the modulo register. Read data is combinational from `bus_addr`.
- R2: Clock select 00 stops the counter. 01 gives one source tick per cycle. 10 gives one tick for each cycle in which `fixed_tick` is 1. 11 gives one tick per rising edge of `ext_clk`, taken after a two-flop synchronizer. A control write changes the selection from the following cycle on.
- R3: With bit 5 at 0 the count rises by one per prescaled tick. The top is the modulo value, or 0xFFFF when the modulo is 0. The tick that finds the count at the top returns it to 0 and sets the flag on that same edge.
- R4: With bit 5 at 1 the count rises to the top, then falls to 0. The tick that finds the count at 0 while it is falling moves it to 1 and sets the flag. With modulo 3 the counts are 1,2,3,2,1,0,1,2.
- R5: The prescaler passes one tick in every 2^PS source ticks, where PS is the value in bits 2:0, so the counter advances once every 1 to 128 source ticks.
- R6: The flag clears when a control write with bit 7 at 0 follows a read of address 0 that saw the flag at 1.
- R7: A control write with bit 7 at 0 that has no such read before it leaves the flag at 1.
- R8: An overflow after the arming read, including one on the same edge as the clearing write, cancels the handshake, and the flag stays 1.
- R9: Writing 1 to bit 7 never changes the flag.
- R10: `irq` is 1 exactly when the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| fixed_tick | input | 1 | One-cycle enable from a fixed-rate source |
| ext_clk | input | 1 | Asynchronous external count clock |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
The delicate case is a clearing write that lands on the same clock edge as a counter wrap. The bench runs the counter from the bus clock with prescale 1 and modulo 7, so it knows the exact edge of each wrap. It places the arming read just after one wrap and the clearing write exactly on the next, then expects the flag still set. It then repeats read and write with no wrap between them and expects the flag clear.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

    localparam int unsigned PS_W = 3;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'b00,
        SRC_BUS   = 2'b01,
        SRC_FIXED = 2'b10,
        SRC_EXT   = 2'b11
    } clk_src_e;

    // MSB first: flag, irq enable, center select, clock select, prescale
    typedef struct packed {
        logic            flag;
        logic            irq_en;
        logic            center;
        clk_src_e        src;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    localparam int unsigned CTRL_W     = $bits(ctrl_t);
    localparam int unsigned ADDR_CTRL  = 0;
    localparam int unsigned ADDR_COUNT = 1;
    localparam int unsigned ADDR_MOD   = 2;

endpackage

// File: rtl/ovf_timer_clksel.sv
module ovf_timer_clksel
    import ovf_timer_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src,
    input  logic     fixed_tick,
    input  logic     ext_clk,
    output logic     tick_o
);

    // synchronizer stages plus one delayed copy for edge detection
    localparam int unsigned SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sel_t;

    sel_t s_d, s_q;
    logic ext_rise;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[SH_W-2:0], ext_clk};
        ext_rise = s_q.sh[SYNC_STAGES-1] & ~s_q.sh[SYNC_STAGES];
        unique case (src)
            SRC_OFF:   tick_o = 1'b0;
            SRC_BUS:   tick_o = 1'b1;
            SRC_FIXED: tick_o = fixed_tick;
            SRC_EXT:   tick_o = ext_rise;
            default:   tick_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/ovf_timer_prescale.sv
module ovf_timer_prescale
    import ovf_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ps,
    input  logic            tick_i,
    output logic            tick_o
);

    localparam int unsigned DIV_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_t;

    pre_t p_d, p_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        p_d  = p_q;
        mask = ~({DIV_W{1'b1}} << ps);
        if (tick_i) p_d.div = p_q.div + 1'b1;
        tick_o = tick_i && ((p_q.div & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R5: with the largest divider, an output tick leaves the divider at zero
    a_r5_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && ps == {PS_W{1'b1}}) |=> (p_q.div == '0));

endmodule

// File: rtl/ovf_timer_counter.sv
module ovf_timer_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [CNT_W-1:0] top;

    always_comb begin
        c_d   = c_q;
        ovf_o = 1'b0;
        top   = (modulo == '0) ? {CNT_W{1'b1}} : modulo;
        if (!center) c_d.down = 1'b0;
        if (tick) begin
            if (!center) begin
                if (c_q.cnt >= top) begin
                    c_d.cnt = '0;
                    ovf_o   = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end else if (!c_q.down) begin
                if (c_q.cnt >= top) begin
                    c_d.down = 1'b1;
                    c_d.cnt  = c_q.cnt - 1'b1;
                end else begin
                    c_d.cnt  = c_q.cnt + 1'b1;
                end
            end else begin
                if (c_q.cnt == '0) begin
                    c_d.down = 1'b0;
                    c_d.cnt  = CNT_W'(1);
                    ovf_o    = 1'b1;
                end else begin
                    c_d.cnt  = c_q.cnt - 1'b1;
                end
            end
        end
        count_o = c_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R3: an up-mode tick at the top lands on zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !center && c_q.cnt >= top) |=> (c_q.cnt == '0));

    // R4: a falling tick at zero turns the sweep upward at one
    a_r4_turn_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && center && c_q.down && c_q.cnt == '0) |=> (c_q.cnt == CNT_W'(1) && !c_q.down));

    // R4: the sweep never rises past the top while counting up
    a_r4_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && center && !c_q.down && c_q.cnt == top) |=> c_q.down);

endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
    import ovf_timer_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fixed_tick,
    input  logic              ext_clk,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam int unsigned PAD_W = CNT_W - CTRL_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic             arm;
        logic [CNT_W-1:0] modulo;
    } regs_t;

    regs_t r_d, r_q;

    logic             src_tick;
    logic             cnt_tick;
    logic             ovf;
    logic [CNT_W-1:0] count;
    logic             rd_ctrl;
    logic             wr_ctrl;
    logic             wr_mod;
    ctrl_t            wr_fields;

    ovf_timer_clksel #(.SYNC_STAGES(SYNC_STAGES)) i_clksel (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (r_q.ctrl.src),
        .fixed_tick (fixed_tick),
        .ext_clk    (ext_clk),
        .tick_o     (src_tick)
    );

    ovf_timer_prescale i_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .ps     (r_q.ctrl.ps),
        .tick_i (src_tick),
        .tick_o (cnt_tick)
    );

    ovf_timer_counter #(.CNT_W(CNT_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .center  (r_q.ctrl.center),
        .modulo  (r_q.modulo),
        .count_o (count),
        .ovf_o   (ovf)
    );

    always_comb begin
        r_d       = r_q;
        rd_ctrl   = bus_rd && (bus_addr == ADDR_W'(ADDR_CTRL));
        wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
        wr_mod    = bus_wr && (bus_addr == ADDR_W'(ADDR_MOD));
        wr_fields = ctrl_t'(bus_wdata[CTRL_W-1:0]);

        if (wr_ctrl) begin
            r_d.ctrl.irq_en = wr_fields.irq_en;
            r_d.ctrl.center = wr_fields.center;
            r_d.ctrl.src    = wr_fields.src;
            r_d.ctrl.ps     = wr_fields.ps;
        end
        if (wr_mod) r_d.modulo = bus_wdata;

        // clear handshake: a new overflow cancels it, any control write ends it
        if (ovf)                          r_d.arm = 1'b0;
        else if (wr_ctrl)                 r_d.arm = 1'b0;
        else if (rd_ctrl && r_q.ctrl.flag) r_d.arm = 1'b1;

        if (ovf)                                        r_d.ctrl.flag = 1'b1;
        else if (wr_ctrl && !wr_fields.flag && r_q.arm) r_d.ctrl.flag = 1'b0;

        unique case (bus_addr)
            ADDR_W'(ADDR_CTRL):  bus_rdata = {{PAD_W{1'b0}}, r_q.ctrl};
            ADDR_W'(ADDR_COUNT): bus_rdata = count;
            ADDR_W'(ADDR_MOD):   bus_rdata = r_q.modulo;
            default:             bus_rdata = '0;
        endcase

        irq = r_q.ctrl.flag && r_q.ctrl.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R2: a stopped source holds the count
    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl.src == SRC_OFF) |=> $stable(count));

    // R3, R4: every overflow leaves the flag set
    a_r3_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> r_q.ctrl.flag);

    // R6, R8: the flag only falls after an armed zero write with no overflow
    a_r8_no_lost_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.ctrl.flag) |-> $past(wr_ctrl && !bus_wdata[CTRL_W-1] && r_q.arm && !ovf));

    // R9: a write of one to the flag never lowers it
    a_r9_one_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[CTRL_W-1] && r_q.ctrl.flag) |=> r_q.ctrl.flag);

endmodule

// File: tb/test_ovf_timer.sv
module test_ovf_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fixed_tick = 1'b0;
    logic        ext_clk = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ovf_timer i_ovf_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fixed_tick (fixed_tick),
        .ext_clk    (ext_clk),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        peek(2'd0, v); chk(v, 16'h0, "R1", "control after reset");
        peek(2'd1, v); chk(v, 16'h0, "R1", "count after reset");
        peek(2'd2, v); chk(v, 16'h0, "R1", "modulo after reset");
        chk(irq, 1'b0, "R1", "irq after reset");
        bus_write(2'd1, 16'h1234);
        peek(2'd1, v); chk(v, 16'h0, "R1", "count write ignored");
        bus_write(2'd2, 16'h00AB);
        peek(2'd2, v); chk(v, 16'h00AB, "R1", "modulo readback");
    endtask

    task automatic t_sources();
        logic [15:0] v;
        do_reset();
        repeat (10) @(negedge clk);
        peek(2'd1, v); chk(v, 16'h0, "R2", "stopped count");
        bus_write(2'd0, 16'h0008);
        repeat (4) @(negedge clk);
        peek(2'd1, v); chk(v, 16'd4, "R2", "bus clock count");
        bus_write(2'd0, 16'h0000);
        repeat (6) @(negedge clk);
        peek(2'd1, v); chk(v, 16'd5, "R2", "count held after stop");
        do_reset();
        bus_write(2'd0, 16'h0010);
        repeat (5) @(negedge clk);
        peek(2'd1, v); chk(v, 16'd0, "R2", "fixed source idle");
        for (int i = 0; i < 3; i++) begin
            fixed_tick = 1'b1;
            @(negedge clk);
            fixed_tick = 1'b0;
            @(negedge clk);
        end
        peek(2'd1, v); chk(v, 16'd3, "R2", "fixed source pulses");
        do_reset();
        bus_write(2'd0, 16'h0018);
        for (int i = 0; i < 5; i++) begin
            ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        peek(2'd1, v); chk(v, 16'd5, "R2", "external rising edges");
    endtask

    task automatic t_up();
        logic [15:0] v;
        do_reset();
        bus_write(2'd2, 16'd5);
        bus_write(2'd0, 16'h0008);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            peek(2'd1, v); chk(v, 16'(k % 6), "R3", $sformatf("up count step %0d", k));
            if (k == 5) begin peek(2'd0, v); chk(v[7], 1'b0, "R3", "flag before wrap"); end
            if (k == 6) begin peek(2'd0, v); chk(v[7], 1'b1, "R3", "flag at wrap"); end
        end
    endtask

    task automatic t_freerun();
        logic [15:0] v;
        do_reset();
        bus_write(2'd0, 16'h0008);
        repeat (65535) @(negedge clk);
        peek(2'd1, v); chk(v, 16'hFFFF, "R3", "free-run top");
        peek(2'd0, v); chk(v[7], 1'b0, "R3", "free-run flag before wrap");
        @(negedge clk);
        peek(2'd1, v); chk(v, 16'h0, "R3", "free-run wrap");
        peek(2'd0, v); chk(v[7], 1'b1, "R3", "free-run flag at wrap");
    endtask

    task automatic t_center();
        logic [15:0] v;
        logic [15:0] seq [8] = '{16'd1, 16'd2, 16'd3, 16'd2, 16'd1, 16'd0, 16'd1, 16'd2};
        do_reset();
        bus_write(2'd2, 16'd3);
        bus_write(2'd0, 16'h0028);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            peek(2'd1, v); chk(v, seq[k-1], "R4", $sformatf("sweep step %0d", k));
            if (k == 6) begin peek(2'd0, v); chk(v[7], 1'b0, "R4", "flag at bottom"); end
            if (k == 7) begin peek(2'd0, v); chk(v[7], 1'b1, "R4", "flag on turn up"); end
        end
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        do_reset();
        bus_write(2'd0, 16'h000A);
        repeat (3) @(negedge clk);
        peek(2'd1, v); chk(v, 16'd0, "R5", "div4 after 3");
        @(negedge clk);
        peek(2'd1, v); chk(v, 16'd1, "R5", "div4 after 4");
        repeat (5) @(negedge clk);
        peek(2'd1, v); chk(v, 16'd2, "R5", "div4 after 9");
        do_reset();
        bus_write(2'd0, 16'h000F);
        repeat (127) @(negedge clk);
        peek(2'd1, v); chk(v, 16'd0, "R5", "div128 after 127");
        @(negedge clk);
        peek(2'd1, v); chk(v, 16'd1, "R5", "div128 after 128");
    endtask

    task automatic t_handshake();
        logic [15:0] v;
        do_reset();
        bus_write(2'd2, 16'd3);
        bus_write(2'd0, 16'h0048);
        repeat (5) @(negedge clk);
        bus_write(2'd0, 16'h0040);
        peek(2'd0, v); chk(v[7], 1'b1, "R7", "unarmed zero write");
        chk(irq, 1'b1, "R10", "irq with flag and enable");
        bus_read(2'd0, v); chk(v[7], 1'b1, "R6", "arming read sees flag");
        bus_write(2'd0, 16'h00C0);
        peek(2'd0, v); chk(v[7], 1'b1, "R9", "one write while armed");
        bus_read(2'd0, v);
        bus_write(2'd0, 16'h0040);
        peek(2'd0, v); chk(v[7], 1'b0, "R6", "armed zero write clears");
        chk(irq, 1'b0, "R10", "irq after clear");
        bus_write(2'd0, 16'h00C0);
        peek(2'd0, v); chk(v[7], 1'b0, "R9", "one write with flag clear");
        bus_write(2'd0, 16'h0008);
        repeat (6) @(negedge clk);
        peek(2'd0, v); chk(v[7], 1'b1, "R10", "flag set again");
        chk(irq, 1'b0, "R10", "irq masked by enable");
    endtask

    task automatic t_cancel();
        logic [15:0] v;
        do_reset();
        bus_write(2'd2, 16'd7);
        bus_write(2'd0, 16'h0008);
        repeat (8) @(negedge clk);
        bus_read(2'd0, v); chk(v[7], 1'b1, "R8", "flag before arming");
        repeat (6) @(negedge clk);
        bus_write(2'd0, 16'h0008);
        peek(2'd0, v); chk(v[7], 1'b1, "R8", "write on overflow edge");
        bus_read(2'd0, v);
        bus_write(2'd0, 16'h0008);
        peek(2'd0, v); chk(v[7], 1'b0, "R6", "clear between overflows");
        do_reset();
        bus_write(2'd2, 16'd3);
        bus_write(2'd0, 16'h0008);
        repeat (4) @(negedge clk);
        bus_read(2'd0, v);
        repeat (5) @(negedge clk);
        bus_write(2'd0, 16'h0008);
        peek(2'd0, v); chk(v[7], 1'b1, "R8", "overflow between read and write");
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_sources();
        t_up();
        t_center();
        t_prescale();
        t_handshake();
        t_cancel();
        t_freerun();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule